// File: doc/BRIEF.md
# Dual-Channel Tone Period Validator

This block decides, for each of two channels, whether a metering tone is present. Each channel receives a stream of digital pulses from an upstream level detector, and each pulse marks the end of 32 cycles of the received tone. The block counts reference clock cycles between consecutive pulse rising edges, so each measured interval is the average tone period over 32 cycles. It compares that interval against an acceptance window. A channel reports the tone as present once a run of three pulses has arrived with both spacings inside the window. It drops the report as soon as a spacing falls outside the window, or as soon as the next pulse is overdue.

Both channels use the same window. One select input picks a 12 kHz or a 16 kHz system. A 2-bit code picks the tolerance. The window limits are computed when the design is built from the reference clock rate (3.579545 MHz by default), so the hardware holds only a small table of eight constant pairs. The outputs are active low, and a shared enable can release both of them so that several devices can share the same lines.

Top module: `tone_period_validator`

## Requirements
- R1: While `rst_n` is low, and until the first valid run after it is released, both `tone_n` bits read 1 (tone absent).
- R2: With F = 12000 when `sys_sel`=0 and F = 16000 when `sys_sel`=1, and T = 15, 30, 50, 75 per mille for `bw_code` = 0, 1, 2, 3, an interval of d reference cycles between rising edges is accepted if and only if floor(32·REF_HZ·1000/(F·(1000+T))) ≤ d ≤ floor(32·REF_HZ·1000/(F·(1000−T))).
- R3: A channel's `tone_n` bit goes to 0 within 3 clock cycles after the rising edge of the third pulse of a run in which both intervals are accepted. After only two pulses it stays at 1.
- R4: An interval that is not accepted sets the channel to tone absent at once. The pulse that ends that interval counts as the first pulse of a new run.
- R5: If more than the window maximum of reference cycles pass with no new rising edge, the channel returns to tone absent. The next pulse counts as the first pulse of a new run.
- R6: Each channel is judged only from its own pulse input. Pulses on one channel never change the other channel's output.
- R7: When `out_en_n` is 1, both `tone_n` bits are undriven, so a pulled-up line reads 1. When `out_en_n` is 0, they drive the inverted presence flag.
- R8: A pulse input is passed through a two-stage synchroniser, and its rising edge is counted exactly once no matter how many cycles the pulse stays high.
- R9: `sys_sel` and `bw_code` set one window that both channels share. A train spaced for 12 kHz is not accepted while 16 kHz with ±1.5% is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (timing base for all intervals) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | NUM_CH | One pulse stream per channel, each pulse marking 32 tone cycles |
| sys_sel | input | 1 | System frequency: 0 = 12 kHz, 1 = 16 kHz |
| bw_code | input | 2 | Tolerance: 0 = ±1.5%, 1 = ±3%, 2 = ±5%, 3 = ±7.5% |
| out_en_n | input | 1 | 1 releases both outputs to high impedance, 0 drives them |
| tone_n | output | NUM_CH | Per channel: 0 = tone present, 1 = tone absent |

## Verification
The hardest case to reach is the exact edge of the window. The spacing between pulses has to land on precisely the minimum or maximum count, and one cycle beyond it, even though the edge passes through a synchroniser first. The bench drives every rising edge from a negative clock edge and puts a fixed number of cycles between rising edges, so the synchroniser delay drops out of the measured interval. It also runs the design at one tenth of the reference rate so that runs stay short, and it computes the limits itself from the R2 formula. A second hard case is a rejected pulse in the middle of an established tone. The bench sends a short spacing right after presence is reached, then checks that exactly two further good pulses bring the tone back.

// File: rtl/tpv_pkg.sv
package tpv_pkg;

  typedef enum logic [1:0] {
    BW_TIGHT  = 2'd0,
    BW_NARROW = 2'd1,
    BW_MEDIUM = 2'd2,
    BW_LOOSE  = 2'd3
  } bw_sel_e;

  // tolerance in parts per thousand for a bandwidth code
  function automatic longint tol_permille(input logic [1:0] code);
    case (bw_sel_e'(code))
      BW_TIGHT:  return 64'd15;
      BW_NARROW: return 64'd30;
      BW_MEDIUM: return 64'd50;
      default:   return 64'd75;
    endcase
  endfunction

  // interval bound in reference cycles; the upper frequency edge gives the short bound
  function automatic longint window_bound(input longint ref_hz, input longint freq_hz,
                                          input longint cyc, input longint tol,
                                          input bit long_side);
    longint num;
    longint den;
    num = cyc * ref_hz * 64'd1000;
    den = freq_hz * (long_side ? (64'd1000 - tol) : (64'd1000 + tol));
    return num / den;
  endfunction

endpackage

// File: rtl/tpv_reset_sync.sv
module tpv_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tpv_pulse_sync.sv
module tpv_pulse_sync #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pulse_in,
  output logic [NUM_CH-1:0] rise_o
);
  logic [NUM_CH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pulse_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/tpv_window_lut.sv
module tpv_window_lut #(
  parameter int CNT_W     = 16,
  parameter int REF_HZ    = 3579545,
  parameter int F_LO_HZ   = 12000,
  parameter int F_HI_HZ   = 16000,
  parameter int PULSE_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_sel,
  input  logic [1:0]       bw_code,
  output logic [CNT_W-1:0] win_lo,
  output logic [CNT_W-1:0] win_hi
);
  localparam int ENTRIES = 8;

  logic [CNT_W-1:0] lo_tab [ENTRIES];
  logic [CNT_W-1:0] hi_tab [ENTRIES];
  logic [2:0]       idx;
  logic [CNT_W-1:0] lo_nxt, hi_nxt;
  logic             upd_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam longint FQ  = (g >= 4) ? longint'(F_HI_HZ) : longint'(F_LO_HZ);
    localparam longint TOL = tpv_pkg::tol_permille(2'(g));
    localparam longint LO  = tpv_pkg::window_bound(longint'(REF_HZ), FQ,
                                                   longint'(PULSE_CYC), TOL, 1'b0);
    localparam longint HI  = tpv_pkg::window_bound(longint'(REF_HZ), FQ,
                                                   longint'(PULSE_CYC), TOL, 1'b1);
    assign lo_tab[g] = CNT_W'(LO);
    assign hi_tab[g] = CNT_W'(HI);
  end

  always_comb begin
    idx    = {sys_sel, bw_code};
    lo_nxt = lo_tab[idx];
    hi_nxt = hi_tab[idx];
    upd_en = (lo_nxt != win_lo) || (hi_nxt != win_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lo <= '0;
      win_hi <= '0;
    end else if (upd_en) begin
      win_lo <= lo_nxt;
      win_hi <= hi_nxt;
    end
  end
endmodule

// File: rtl/tpv_channel.sv
module tpv_channel #(
  parameter int CNT_W      = 16,
  parameter int RUN_TARGET = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] win_lo,
  input  logic [CNT_W-1:0] win_hi,
  output logic [CNT_W-1:0] ivl_cnt,
  output logic             present_o
);
  localparam int RUN_W = $clog2(RUN_TARGET + 1);

  logic [RUN_W-1:0] run_q, run_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             pres_nxt;
  logic             in_window;
  logic             overdue;
  logic             cnt_en, run_en;

  always_comb begin
    cnt_nxt   = ivl_cnt;
    run_nxt   = run_q;
    pres_nxt  = present_o;
    in_window = (ivl_cnt >= win_lo) && (ivl_cnt <= win_hi);
    overdue   = ivl_cnt > win_hi;
    if (rise_i) begin
      cnt_nxt = CNT_W'(1);
      if (run_q == '0) begin
        run_nxt  = RUN_W'(1);
        pres_nxt = 1'b0;
      end else if (in_window) begin
        if (int'(run_q) < RUN_TARGET) run_nxt = run_q + RUN_W'(1);
        if (int'(run_q) + 1 >= RUN_TARGET) pres_nxt = 1'b1;
      end else begin
        run_nxt  = RUN_W'(1);
        pres_nxt = 1'b0;
      end
    end else begin
      if (ivl_cnt != '1) cnt_nxt = ivl_cnt + CNT_W'(1);
      if (overdue) begin
        run_nxt  = '0;
        pres_nxt = 1'b0;
      end
    end
    cnt_en = (cnt_nxt != ivl_cnt);
    run_en = (run_nxt != run_q) || (pres_nxt != present_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ivl_cnt <= '0;
    else if (cnt_en) ivl_cnt <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      present_o <= 1'b0;
    end else if (run_en) begin
      run_q     <= run_nxt;
      present_o <= pres_nxt;
    end
  end
endmodule

// File: rtl/tone_period_validator.sv
module tone_period_validator #(
  parameter int NUM_CH     = 2,
  parameter int CNT_W      = 16,
  parameter int REF_HZ     = 3579545,
  parameter int F_LO_HZ    = 12000,
  parameter int F_HI_HZ    = 16000,
  parameter int PULSE_CYC  = 32,
  parameter int RUN_TARGET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pulse_in,
  input  logic              sys_sel,
  input  logic [1:0]        bw_code,
  input  logic              out_en_n,
  output logic [NUM_CH-1:0] tone_n
);
  logic                    rst_sync_n;
  logic [NUM_CH-1:0]       pulse_rise;
  logic [NUM_CH-1:0]       tone_present;
  logic [CNT_W-1:0]        win_lo, win_hi;
  logic [NUM_CH*CNT_W-1:0] ivl_cnt_flat;

  tpv_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tpv_pulse_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pulse_in (pulse_in),
    .rise_o   (pulse_rise)
  );

  tpv_window_lut #(
    .CNT_W(CNT_W), .REF_HZ(REF_HZ), .F_LO_HZ(F_LO_HZ),
    .F_HI_HZ(F_HI_HZ), .PULSE_CYC(PULSE_CYC)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sys_sel (sys_sel),
    .bw_code (bw_code),
    .win_lo  (win_lo),
    .win_hi  (win_hi)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tpv_channel #(.CNT_W(CNT_W), .RUN_TARGET(RUN_TARGET)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .rise_i    (pulse_rise[c]),
      .win_lo    (win_lo),
      .win_hi    (win_hi),
      .ivl_cnt   (ivl_cnt_flat[c*CNT_W +: CNT_W]),
      .present_o (tone_present[c])
    );
  end

  assign tone_n = out_en_n ? {NUM_CH{1'bz}} : ~tone_present;
endmodule

// File: rtl/tpv_checker.sv
module tpv_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_sync_n,
  input logic [NUM_CH-1:0]       pulse_rise,
  input logic [NUM_CH-1:0]       tone_present,
  input logic [NUM_CH*CNT_W-1:0] ivl_cnt_flat,
  input logic [CNT_W-1:0]        win_lo,
  input logic [CNT_W-1:0]        win_hi
);
  p_absent_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (tone_present == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_presence_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(tone_present[c]) |-> $past(pulse_rise[c]));

    p_short_gap_drops_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pulse_rise[c] && (ivl_cnt_flat[c*CNT_W +: CNT_W] < win_lo)) |=> !tone_present[c]);

    p_overdue_drops_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!pulse_rise[c] && (ivl_cnt_flat[c*CNT_W +: CNT_W] > win_hi)) |=> !tone_present[c]);

    p_edge_restarts_count_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pulse_rise[c] |=> (ivl_cnt_flat[c*CNT_W +: CNT_W] == CNT_W'(1)));

    p_single_cycle_edge_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pulse_rise[c] |=> !pulse_rise[c]);
  end
endmodule

bind tone_period_validator tpv_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_tpv_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .pulse_rise   (pulse_rise),
  .tone_present (tone_present),
  .ivl_cnt_flat (ivl_cnt_flat),
  .win_lo       (win_lo),
  .win_hi       (win_hi)
);

// File: tb/tb_tone_period_validator.sv
module tb_tone_period_validator;
  localparam int NCH    = 2;
  localparam int REF    = 357954;
  localparam int SETTLE = 4;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] pulse_in;
  logic           sys_sel;
  logic [1:0]     bw_code;
  logic           out_en_n;
  tri1 [NCH-1:0]  tone_w;

  int checks;
  int errors;

  tone_period_validator #(.NUM_CH(NCH), .REF_HZ(REF)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_in (pulse_in),
    .sys_sel  (sys_sel),
    .bw_code  (bw_code),
    .out_en_n (out_en_n),
    .tone_n   (tone_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int tol_of(input logic [1:0] code);
    case (code)
      2'd0: return 15;
      2'd1: return 30;
      2'd2: return 50;
      default: return 75;
    endcase
  endfunction

  function automatic int lim(input logic sel, input logic [1:0] code, input bit hi);
    longint f;
    longint t;
    f = sel ? 64'd16000 : 64'd12000;
    t = longint'(tol_of(code));
    if (hi) return int'((64'd32 * REF * 64'd1000) / (f * (64'd1000 - t)));
    return int'((64'd32 * REF * 64'd1000) / (f * (64'd1000 + t)));
  endfunction

  task automatic check(input string req, input logic [NCH-1:0] exp);
    checks++;
    if (tone_w !== exp) begin
      errors++;
      $display("FAIL %s: tone_n=%b expected %b at %0t", req, tone_w, exp, $time);
    end
  endtask

  task automatic first_pulse(input logic [NCH-1:0] mask, input int width);
    @(negedge clk) pulse_in = pulse_in | mask;
    repeat (width) @(negedge clk);
    pulse_in = pulse_in & ~mask;
    repeat (SETTLE) @(negedge clk);
  endtask

  // next rising edge lands exactly d cycles after the previous one
  task automatic next_pulse(input logic [NCH-1:0] mask, input int d, input int width);
    repeat (d - width - SETTLE - 1) @(negedge clk);
    first_pulse(mask, width);
  endtask

  task automatic go_idle();
    repeat (1500) @(negedge clk);
  endtask

  task automatic set_window(input logic sel, input logic [1:0] code);
    @(negedge clk);
    sys_sel = sel;
    bw_code = code;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    pulse_in = '0;
    sys_sel = 1'b0;
    bw_code = 2'd1;
    out_en_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 during reset", 2'b11);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 after reset", 2'b11);
  endtask

  task automatic t_nominal_run();
    set_window(1'b0, 2'd1);
    first_pulse(2'b01, 2);
    next_pulse(2'b01, 954, 2);
    check("R3 two pulses not enough", 2'b11);
    next_pulse(2'b01, 954, 2);
    check("R3 third good pulse", 2'b10);
    go_idle();
    check("R5 idle after run", 2'b11);
  endtask

  task automatic t_boundary(input int d, input logic [NCH-1:0] exp, input string req);
    first_pulse(2'b01, 2);
    next_pulse(2'b01, d, 2);
    next_pulse(2'b01, d, 2);
    check(req, exp);
    go_idle();
  endtask

  task automatic t_edges();
    int lo;
    int hi;
    set_window(1'b0, 2'd0);
    lo = lim(1'b0, 2'd0, 1'b0);
    hi = lim(1'b0, 2'd0, 1'b1);
    t_boundary(lo,     2'b10, "R2 interval at minimum accepted");
    t_boundary(lo - 1, 2'b11, "R2 interval below minimum rejected");
    t_boundary(hi,     2'b10, "R2 interval at maximum accepted");
    t_boundary(hi + 1, 2'b11, "R2 interval above maximum rejected");
  endtask

  task automatic t_short_restart();
    int lo;
    set_window(1'b0, 2'd1);
    lo = lim(1'b0, 2'd1, 1'b0);
    first_pulse(2'b01, 2);
    next_pulse(2'b01, 954, 2);
    next_pulse(2'b01, 954, 2);
    check("R4 tone established", 2'b10);
    next_pulse(2'b01, lo - 1, 2);
    check("R4 short interval drops tone", 2'b11);
    next_pulse(2'b01, 954, 2);
    check("R4 short pulse began new run", 2'b11);
    next_pulse(2'b01, 954, 2);
    check("R4 tone back after new run", 2'b10);
    go_idle();
  endtask

  task automatic t_timeout();
    int hi;
    set_window(1'b0, 2'd1);
    hi = lim(1'b0, 2'd1, 1'b1);
    first_pulse(2'b01, 2);
    next_pulse(2'b01, 954, 2);
    next_pulse(2'b01, 954, 2);
    repeat (hi - 12) @(negedge clk);
    check("R5 still present before limit", 2'b10);
    repeat (20) @(negedge clk);
    check("R5 overdue pulse drops tone", 2'b11);
    first_pulse(2'b01, 2);
    next_pulse(2'b01, 954, 2);
    check("R5 late pulse began new run", 2'b11);
    go_idle();
  endtask

  task automatic t_long_pulses();
    set_window(1'b0, 2'd1);
    first_pulse(2'b01, 60);
    next_pulse(2'b01, 954, 60);
    next_pulse(2'b01, 954, 60);
    check("R8 wide pulses counted once", 2'b10);
    go_idle();
  endtask

  task automatic t_channels_and_enable();
    set_window(1'b0, 2'd1);
    first_pulse(2'b10, 2);
    next_pulse(2'b10, 954, 2);
    next_pulse(2'b10, 954, 2);
    check("R6 only channel 1 present", 2'b01);
    @(negedge clk) out_en_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 outputs released", 2'b11);
    @(negedge clk) out_en_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 outputs driven again", 2'b01);
    go_idle();
  endtask

  task automatic t_high_system();
    set_window(1'b1, 2'd3);
    first_pulse(2'b11, 2);
    next_pulse(2'b11, 716, 2);
    next_pulse(2'b11, 716, 2);
    check("R9 16 kHz run both channels", 2'b00);
    go_idle();
    set_window(1'b1, 2'd0);
    first_pulse(2'b01, 2);
    next_pulse(2'b01, 954, 2);
    next_pulse(2'b01, 954, 2);
    check("R9 12 kHz spacing rejected at 16 kHz", 2'b11);
    go_idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_nominal_run();
    t_edges();
    t_short_restart();
    t_timeout();
    t_long_pulses();
    t_channels_and_enable();
    t_high_system();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end
endmodule